// File: doc/BRIEF.md
# Instruction-Counted Single-Step Interrupt Timer

This block sits on the bus of an 8-bit processor whose non-maskable interrupt responds to a falling edge. A debugger writes a control register with the trigger bit set, then executes a return-from-interrupt. The block counts whole instructions, not clock cycles. It pulls the interrupt line low once two instructions have completed after the arming instruction, so exactly one instruction of the program under test runs before the debugger regains control.

The processor advances only on cycles where the clock enable is high. It marks the final cycle of each instruction with an end-of-instruction strobe, and the block counts those strobes. The interrupt line stays low until the processor reads either byte of the interrupt vector. It is then released, so the next arming can produce a fresh falling edge. Re-arming before every return steps through a program one instruction at a time.

Top module: `sstep_nmi_timer`

## Requirements
- R1: After synchronous reset, `nmi_n` is 1 and the armed flag is 0, so a read of the control address returns 0x00.
- R2: An enabled write to address 0xFFDE with data bit 4 set arms the timer. While the timer is armed, `rd_data` at address 0xFFDE is 0x10. It is 0x00 when the timer is not armed, and always 0x00 at other addresses.
- R3: A write to 0xFFDE with bit 4 clear, or a write with bit 4 set to any other address, leaves the timer unarmed and `nmi_n` high.
- R4: When the arming write is not on an end-of-instruction cycle, the next enabled end-of-instruction strobe belongs to the arming instruction and is not counted.
- R5: When the arming write happens on an end-of-instruction cycle, that strobe is not counted and no later strobe is skipped.
- R6: A multi-cycle instruction counts once. `nmi_n` goes low on the clock edge that samples the second counted end-of-instruction strobe, and not before.
- R7: On cycles with `cpu_ce` low, the write, read and end-of-instruction inputs have no effect.
- R8: The armed flag clears on the same edge where `nmi_n` falls, so bit 4 of the read data then returns 0.
- R9: `nmi_n` stays low until an enabled read of 0xFFFC or 0xFFFD, and goes high on that edge. Reads of other addresses do not release it.
- R10: An arming write while the timer is already armed restarts the count from zero, with the skip rule of R4 or R5 applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_ce | input | 1 | Processor clock enable; the bus is sampled only when it is high |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| instr_end | input | 1 | High on the final cycle of an instruction |
| rd_data | output | 8 | Control register read value, zero when another address is selected |
| nmi_n | output | 1 | Non-maskable interrupt request, active low, registered |

## Verification
Every registered result is due on the first rising edge that samples the enabled stimulus. The arm flag, the count, the falling `nmi_n` and its release on a vector fetch are all visible one edge after their input cycle. The bench drives each cycle's inputs after the falling edge and checks one time unit after the next rising edge, so it sees the post-edge value and never a race. The read value is combinational on the address and is checked before any edge. A reference model built from the requirements advances only on enabled cycles and predicts `nmi_n` and the armed bit for every directed and random cycle.

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic arm;    // enabled write to control register with trigger bit
    logic vec;    // enabled read of either interrupt vector byte
    logic bnd;    // enabled end-of-instruction strobe
  } sstep_evt_t;
endpackage

// File: rtl/sstep_decode.sv
module sstep_decode
  import sstep_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFDE,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'hFFFC,
  parameter int                ARM_BIT   = 4
) (
  input  logic              cpu_ce,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic              instr_end,
  output logic              ctrl_sel,
  output sstep_evt_t        evt
);
  localparam int VEC_MSB = ADDR_W - 1;

  logic vec_sel;

  always_comb begin
    ctrl_sel = (bus_addr == CTRL_ADDR);
    vec_sel  = (bus_addr[VEC_MSB:1] == VEC_ADDR[VEC_MSB:1]);
    evt.arm  = cpu_ce && bus_we && ctrl_sel && bus_wdata[ARM_BIT];
    evt.vec  = cpu_ce && bus_rd && vec_sel;
    evt.bnd  = cpu_ce && instr_end;
  end
endmodule

// File: rtl/sstep_counter.sv
module sstep_counter
  import sstep_pkg::*;
#(
  parameter int STEPS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_ce,
  input  sstep_evt_t evt,
  output logic       armed,
  output logic       fire
);
  localparam int CW = (STEPS < 2) ? 1 : $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          skip;
  logic [CW-1:0] cnt;

  always_comb fire = armed && !skip && evt.bnd && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      skip  <= 1'b0;
      cnt   <= '0;
    end else if (evt.arm) begin
      armed <= 1'b1;
      cnt   <= '0;
      skip  <= !evt.bnd;
    end else if (fire) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && evt.bnd) begin
      if (skip) skip <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt <= LAST));                                  // R6
  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (rst)
    evt.arm |=> (armed && cnt == '0));                         // R10
  AST_FIRE_DISARM: assert property (@(posedge clk) disable iff (rst)
    (fire && !evt.arm) |=> !armed);                            // R8
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cpu_ce |=> ($stable(cnt) && $stable(armed) && $stable(skip))); // R7
endmodule

// File: rtl/sstep_nmi_drive.sv
module sstep_nmi_drive
  import sstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  sstep_evt_t evt,
  output logic       nmi_n
);
  always_ff @(posedge clk) begin
    if (rst)          nmi_n <= 1'b1;
    else if (fire)    nmi_n <= 1'b0;
    else if (evt.vec) nmi_n <= 1'b1;
  end

  AST_NMI_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (nmi_n && !fire) |=> nmi_n);                               // R6
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!nmi_n && !evt.vec) |=> !nmi_n);                          // R9
  AST_NMI_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (evt.vec && !fire) |=> nmi_n);                             // R9
endmodule

// File: rtl/sstep_nmi_timer.sv
module sstep_nmi_timer
  import sstep_pkg::*;
#(
  parameter logic [15:0] CTRL_ADDR = 16'hFFDE,
  parameter logic [15:0] VEC_ADDR  = 16'hFFFC,
  parameter int          ARM_BIT   = 4,
  parameter int          STEPS     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_ce,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  input  logic        bus_rd,
  input  logic        instr_end,
  output logic [7:0]  rd_data,
  output logic        nmi_n
);
  sstep_evt_t evt;
  logic       ctrl_sel;
  logic       armed;
  logic       fire;

  sstep_decode #(.CTRL_ADDR(CTRL_ADDR), .VEC_ADDR(VEC_ADDR), .ARM_BIT(ARM_BIT)) u_dec (
    .cpu_ce(cpu_ce), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rd(bus_rd), .instr_end(instr_end), .ctrl_sel(ctrl_sel), .evt(evt)
  );

  sstep_counter #(.STEPS(STEPS)) u_cnt (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .evt(evt), .armed(armed), .fire(fire)
  );

  sstep_nmi_drive u_drv (
    .clk(clk), .rst(rst), .fire(fire), .evt(evt), .nmi_n(nmi_n)
  );

  always_comb begin
    rd_data = '0;
    if (ctrl_sel) rd_data[ARM_BIT] = armed;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (nmi_n && !armed));                                // R1
  AST_READ_FIELD: assert property (@(posedge clk) disable iff (rst)
    ($countones(rd_data) <= 1) && (rd_data[ARM_BIT] == (ctrl_sel && armed))); // R2
endmodule

// File: tb/sstep_nmi_timer_test.sv
module sstep_nmi_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTRL = 16'hFFDE;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_ce;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        bus_rd;
  logic        instr_end;
  logic [7:0]  rd_data;
  logic        nmi_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  bit m_armed, m_skip, m_nmi_n;
  int m_cnt;

  sstep_nmi_timer uut (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rd(bus_rd), .instr_end(instr_end), .rd_data(rd_data), .nmi_n(nmi_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
      summary();
    end
  end

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_arm(bit ce, bit [15:0] a, bit we, bit [7:0] wd);
    return ce && we && (a == CTRL) && wd[4];
  endfunction

  function automatic bit is_vec(bit ce, bit [15:0] a, bit rd);
    return ce && rd && (a[15:1] == 15'h7FFE);
  endfunction

  task automatic model(bit ce, bit [15:0] a, bit we, bit rd, bit [7:0] wd, bit ie);
    bit arm, vec, bnd, fire;
    arm  = is_arm(ce, a, we, wd);
    vec  = is_vec(ce, a, rd);
    bnd  = ce && ie;
    fire = m_armed && !m_skip && bnd && (m_cnt == 1);
    if (fire) m_nmi_n = 0;
    else if (vec) m_nmi_n = 1;
    if (arm) begin m_armed = 1; m_cnt = 0; m_skip = !bnd; end
    else if (fire) begin m_armed = 0; m_cnt = 0; end
    else if (m_armed && bnd) begin
      if (m_skip) m_skip = 0; else m_cnt++;
    end
  endtask

  task automatic cyc(bit ce, bit [15:0] a, bit we, bit rd, bit [7:0] wd, bit ie);
    @(negedge clk);
    cpu_ce = ce; bus_addr = a; bus_we = we; bus_rd = rd; bus_wdata = wd; instr_end = ie;
    @(posedge clk);
    #1;
    model(ce, a, we, rd, wd, ie);
  endtask

  task automatic idle(bit ie);
    cyc(1'b1, 16'h1000, 1'b0, 1'b1, 8'h00, ie);
  endtask

  task automatic arm_wr(bit ie);
    cyc(1'b1, CTRL, 1'b1, 1'b0, 8'h10, ie);
  endtask

  task automatic check_read(string req);
    @(negedge clk);
    cpu_ce = 1'b0; bus_we = 1'b0; bus_rd = 1'b0; instr_end = 1'b0; bus_addr = CTRL;
    #1;
    expect_eq(req, rd_data, m_armed ? 8'h10 : 8'h00);
  endtask

  initial begin
    bit ce, we, rd, ie;
    bit [15:0] a;
    bit [7:0] wd;
    int r;
    void'($urandom(32'h5EED1234));
    rst = 1'b1; cpu_ce = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0; bus_rd = 0; instr_end = 0;
    m_armed = 0; m_skip = 0; m_nmi_n = 1; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check_read("R1 read after reset");
    expect_eq("R1 nmi_n after reset", nmi_n, 1);
    // R2 read at other address is zero
    @(negedge clk); bus_addr = 16'h1234; #1;
    expect_eq("R2 read other addr", rd_data, 0);

    // R3 non-arming writes
    cyc(1, CTRL, 1, 0, 8'hEF, 1);
    cyc(1, 16'hFFDF, 1, 0, 8'h10, 1);
    idle(1); idle(1); idle(1);
    check_read("R3 not armed");
    expect_eq("R3 nmi_n high", nmi_n, 1);

    // R4, R6: arm mid-instruction; arming instr ends, RTI 3 cycles, user instr 2 cycles
    arm_wr(0);
    check_read("R2 armed read");
    idle(1);                       // end of arming instruction (skipped)
    idle(0); idle(0); idle(1);     // multi-cycle return
    expect_eq("R4 no nmi after first counted", nmi_n, 1);
    idle(0);
    expect_eq("R6 no nmi mid second", nmi_n, 1);
    idle(1);
    expect_eq("R6 nmi low at second boundary", nmi_n, 0);
    check_read("R8 armed cleared on fire");
    // R9 hold until vector fetch
    idle(1); cyc(1, 16'hFFFB, 0, 1, 0, 0);
    expect_eq("R9 hold without vector read", nmi_n, 0);
    cyc(0, 16'hFFFC, 0, 1, 0, 0);
    expect_eq("R7 gated vector read ignored", nmi_n, 0);
    cyc(1, 16'hFFFD, 0, 1, 0, 0);
    expect_eq("R9 released by vector read", nmi_n, 1);

    // R5: arming write on boundary
    arm_wr(1);
    idle(1);
    expect_eq("R5 one counted", nmi_n, 1);
    idle(1);
    expect_eq("R5 nmi after two", nmi_n, 0);
    cyc(1, 16'hFFFC, 0, 1, 0, 0);
    expect_eq("R9 release low byte", nmi_n, 1);

    // R7: gated cycles ignored
    arm_wr(1);
    cyc(0, 16'h1000, 0, 0, 0, 1); cyc(0, 16'h1000, 0, 0, 0, 1); cyc(0, 16'h1000, 0, 0, 0, 1);
    expect_eq("R7 gated boundaries ignored", nmi_n, 1);
    check_read("R7 still armed");

    // R10: rearm restarts count
    idle(1);                       // count 1
    arm_wr(0);                     // restart
    idle(1);                       // skipped
    idle(1);
    expect_eq("R10 restart holds nmi high", nmi_n, 1);
    idle(1);
    expect_eq("R10 fires after restart", nmi_n, 0);
    cyc(1, 16'hFFFC, 0, 1, 0, 0);

    // random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      ce = ($urandom % 4) != 0;
      ie = ($urandom % 3) == 0;
      r  = $urandom % 20;
      we = 0; rd = 0; wd = 8'($urandom); a = 16'($urandom);
      if (r == 0) begin a = CTRL; we = 1; wd[4] = 1; end
      else if (r == 1) begin a = 16'hFFFC | 16'($urandom % 2); rd = 1; end
      else if (r == 2) begin a = CTRL; we = 1; end
      else rd = 1;
      cyc(ce, a, we, rd, wd, ie);
      expect_eq("R6 random nmi_n", nmi_n, m_nmi_n);
      if (i % 16 == 0) check_read("R2 random armed read");
    end
    summary();
  end
endmodule